// File: doc/BRIEF.md
# Lookahead-Enabled Multistage Up/Down Counter

This block is a wide reversible binary counter made of several 4-bit stages that all run from one clock. Each stage's advance condition comes from a flat gate. The gate combines the global run enable with the limit flags of every lower stage, so the carry needs no ripple path. All stages that change, change on the same rising edge.

A stage's limit flag means all-ones when counting up and all-zeros when counting down. Because the flag follows the direction, the same gate serves as both the carry and the borrow. An active-low asynchronous load presets every stage at once from a parallel word and overrides counting. An overall limit output tells the user when the full-width value sits at the extreme for the selected direction.

Top module: `lacnt_counter`

## Requirements
- R1: With `load_n` high, a rising clock edge with `rst` high sets `count` to zero.
- R2: With `load_n` high, `rst` low, `cnt_en_n` low and `dir_down` low, each rising edge sets `count` to its previous value plus one, modulo 2^(4·N_STAGES).
- R3: With `load_n` high, `rst` low, `cnt_en_n` low and `dir_down` high, each rising edge sets `count` to its previous value minus one, modulo 2^(4·N_STAGES).
- R4: With `cnt_en_n` high, `load_n` high and `rst` low, `count` does not change. This holds in either direction and when every lower stage sits at its limit.
- R5: Stage k (bits 4k+3..4k) advances only on an edge where every lower stage is at its limit for the current direction. All advancing stages change on that same edge, for example 0x0FFF up to 0x1000 and 0x1000 down to 0x0FFF in one edge.
- R6: A falling `load_n` copies `load_val` into `count` without any clock edge. While `load_n` stays low, every rising edge reloads `load_val`, with counting and `rst` both ignored.
- R7: `term_cnt` is 1 exactly when `count` is all ones with `dir_down` = 0, or all zeros with `dir_down` = 1. It follows a change of `dir_down` without a clock edge and does not depend on `cnt_en_n`.
- R8: Counting wraps in both directions: all ones up gives zero, and zero down gives all ones, in one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages, rising edge |
| rst | input | 1 | Synchronous active-high reset to zero |
| cnt_en_n | input | 1 | Global count enable, active low |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous parallel load, active low |
| load_val | input | 4·N_STAGES | Parallel preset word |
| count | output | 4·N_STAGES | Full counter value |
| term_cnt | output | 1 | Full-width limit for the current direction |

## Verification
The bench builds the block with the default of four stages, a 16-bit word. At that width a full up cycle of 65536 edges can be checked one step at a time against a reference modulo-65536 counter. That run crosses every stage boundary, including the three-stage carry at 0x0FFF and the wrap at 0xFFFF. Loads to chosen words close to the stage boundaries bring the borrow cases, the wrap at zero and the direction-dependent limit flag within a few edges.

// File: rtl/lacnt_pkg.sv
`timescale 1ns/1ps
package lacnt_pkg;

    localparam int unsigned NIB_W = 4;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic step;
        dir_e dir;
    } stage_ctl_t;

    function automatic logic at_limit(input logic [NIB_W-1:0] v, input dir_e d);
        return (d == DIR_DOWN) ? (v == '0) : (&v);
    endfunction

    function automatic logic [NIB_W-1:0] step_value(input logic [NIB_W-1:0] v, input dir_e d);
        return (d == DIR_DOWN) ? (v - 1'b1) : (v + 1'b1);
    endfunction

endpackage

// File: rtl/lacnt_stage.sv
`timescale 1ns/1ps
module lacnt_stage
    import lacnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic [NIB_W-1:0] load_d,
    input  stage_ctl_t       ctl,
    output logic [NIB_W-1:0] q,
    output logic             tc
);

    logic [NIB_W-1:0] q_r;

    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            q_r <= load_d;
        end else if (rst) begin
            q_r <= '0;
        end else if (ctl.step) begin
            q_r <= step_value(q_r, ctl.dir);
        end
    end

    assign q  = q_r;
    assign tc = at_limit(q_r, ctl.dir);

endmodule

// File: rtl/lacnt_carry.sv
`timescale 1ns/1ps
module lacnt_carry #(
    parameter int unsigned N = 4
) (
    input  logic         run,
    input  logic [N-1:0] tc,
    output logic [N-1:0] step,
    output logic         all_tc
);

    for (genvar i = 0; i < N; i++) begin : g_gate
        if (i == 0) begin : g_first
            assign step[i] = run;
        end else begin : g_upper
            // flat gate: run enable and every lower limit flag, no chain
            assign step[i] = run & (&tc[i-1:0]);
        end
    end

    assign all_tc = &tc;

endmodule

// File: rtl/lacnt_counter.sv
`timescale 1ns/1ps
module lacnt_counter
    import lacnt_pkg::*;
#(
    parameter  int unsigned N_STAGES = 4,
    localparam int unsigned CNT_W    = N_STAGES * NIB_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    input  logic             load_n,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             term_cnt
);

    dir_e                dir;
    logic                run_en;
    logic [N_STAGES-1:0] tc_vec;
    logic [N_STAGES-1:0] step_vec;

    assign dir    = dir_e'(dir_down);
    assign run_en = ~cnt_en_n;

    lacnt_carry #(.N(N_STAGES)) u_carry (
        .run    (run_en),
        .tc     (tc_vec),
        .step   (step_vec),
        .all_tc (term_cnt)
    );

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        stage_ctl_t ctl;
        assign ctl.step = step_vec[g];
        assign ctl.dir  = dir;

        lacnt_stage u_stage (
            .clk    (clk),
            .rst    (rst),
            .load_n (load_n),
            .load_d (load_val[g*NIB_W +: NIB_W]),
            .ctl    (ctl),
            .q      (count[g*NIB_W +: NIB_W]),
            .tc     (tc_vec[g])
        );
    end

endmodule

// File: rtl/lacnt_counter_chk.sv
`timescale 1ns/1ps
module lacnt_counter_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en_n,
    input logic         dir_down,
    input logic         load_n,
    input logic [W-1:0] load_val,
    input logic [W-1:0] count,
    input logic         term_cnt
);

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && !$past(rst) && !$past(cnt_en_n) && !$past(dir_down))
        |-> count == W'($past(count) + 1'b1)); // R2

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && !$past(rst) && !$past(cnt_en_n) && $past(dir_down))
        |-> count == W'($past(count) - 1'b1)); // R3

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && !$past(rst) && $past(cnt_en_n))
        |-> $stable(count)); // R4

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (!load_n && !$past(load_n) && $stable(load_val))
        |-> count == load_val); // R6

    AST_LIMIT_FLAG: assert property (@(posedge clk) disable iff (rst)
        term_cnt == (dir_down ? (count == '0) : (&count))); // R7

endmodule

bind lacnt_counter lacnt_counter_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_en_n (cnt_en_n),
    .dir_down (dir_down),
    .load_n   (load_n),
    .load_val (load_val),
    .count    (count),
    .term_cnt (term_cnt)
);

// File: tb/lacnt_counter_bench.sv
`timescale 1ns/1ps
module lacnt_counter_bench;

    localparam int unsigned N_STAGES = 4;
    localparam int unsigned W        = N_STAGES * 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en_n = 1'b1;
    logic         dir_down = 1'b0;
    logic         load_n = 1'b1;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] count;
    logic         term_cnt;

    logic [W-1:0] ref_q;
    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lacnt_counter #(.N_STAGES(N_STAGES)) u_lacnt_counter (
        .clk      (clk),
        .rst      (rst),
        .cnt_en_n (cnt_en_n),
        .dir_down (dir_down),
        .load_n   (load_n),
        .load_val (load_val),
        .count    (count),
        .term_cnt (term_cnt)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_tc(input string tag);
        logic exp;
        exp = dir_down ? (ref_q == '0) : (&ref_q);
        n_chk++;
        if (term_cnt !== exp) begin
            n_fail++;
            $display("FAIL %s: term_cnt got %b expected %b", tag, term_cnt, exp);
        end
    endtask

    // one rising edge, reference update, then sample at the falling edge
    task automatic tick();
        @(posedge clk);
        if (!load_n)        ref_q = load_val;
        else if (rst)       ref_q = '0;
        else if (!cnt_en_n) ref_q = dir_down ? ref_q - 1'b1 : ref_q + 1'b1;
        @(negedge clk);
    endtask

    // asynchronous preset held across one edge, then released
    task automatic do_load(input logic [W-1:0] v);
        load_val = v;
        load_n   = 1'b0;
        #2;
        check("R6 async preset", count, v);
        tick();
        load_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; load_n = 1'b1; cnt_en_n = 1'b0;
        tick(); tick();
        check("R1 reset", count, '0);
        rst = 1'b0;
    endtask

    task automatic t_up();
        do_load(16'h1234);
        cnt_en_n = 1'b0; dir_down = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick();
            check("R2 count up", count, ref_q);
        end
        check("R2 after 20 up", count, 16'h1248);
    endtask

    task automatic t_down();
        do_load(16'h8003);
        cnt_en_n = 1'b0; dir_down = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            check("R3 count down", count, ref_q);
        end
        check("R3 after 20 down", count, 16'h7FEF);
    endtask

    task automatic t_hold();
        do_load(16'h0FFF);
        cnt_en_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            dir_down = i[0];
            tick();
            check("R4 hold", count, 16'h0FFF);
        end
        dir_down = 1'b0;
        tick();
        check("R4 hold with lower stages at limit", count, 16'h0FFF);
    endtask

    task automatic t_carry();
        cnt_en_n = 1'b1;
        dir_down = 1'b0;
        do_load(16'h0FFF); cnt_en_n = 1'b0; tick(); cnt_en_n = 1'b1;
        check("R5 three-stage carry", count, 16'h1000);
        do_load(16'h00FF); cnt_en_n = 1'b0; tick(); cnt_en_n = 1'b1;
        check("R5 two-stage carry", count, 16'h0100);
        do_load(16'h000F); cnt_en_n = 1'b0; tick(); cnt_en_n = 1'b1;
        check("R5 one-stage carry", count, 16'h0010);
        dir_down = 1'b1;
        do_load(16'h1000); cnt_en_n = 1'b0; tick(); cnt_en_n = 1'b1;
        check("R5 three-stage borrow", count, 16'h0FFF);
        do_load(16'h0100); cnt_en_n = 1'b0; tick(); cnt_en_n = 1'b1;
        check("R5 two-stage borrow", count, 16'h00FF);
        do_load(16'h0F0F); cnt_en_n = 1'b0; tick(); cnt_en_n = 1'b1;
        check("R5 no borrow past nonzero stage", count, 16'h0F0E);
    endtask

    task automatic t_wrap();
        cnt_en_n = 1'b1; dir_down = 1'b0;
        do_load(16'hFFFF); cnt_en_n = 1'b0; tick(); cnt_en_n = 1'b1;
        check("R8 wrap up", count, 16'h0000);
        dir_down = 1'b1;
        do_load(16'h0000); cnt_en_n = 1'b0; tick(); cnt_en_n = 1'b1;
        check("R8 wrap down", count, 16'hFFFF);
    endtask

    task automatic t_tc();
        cnt_en_n = 1'b1; dir_down = 1'b0;
        do_load(16'hFFFF);
        check_tc("R7 all ones up");
        dir_down = 1'b1; #2;
        check_tc("R7 all ones down");
        do_load(16'h0000);
        check_tc("R7 zero down");
        dir_down = 1'b0; #2;
        check_tc("R7 zero up");
        cnt_en_n = 1'b0; dir_down = 1'b1; #2;
        check_tc("R7 zero down while enabled");
        cnt_en_n = 1'b1; dir_down = 1'b0;
        do_load(16'h0FFF);
        check_tc("R7 partial ones up");
    endtask

    task automatic t_load_held();
        cnt_en_n = 1'b0; dir_down = 1'b0;
        load_val = 16'hA5C3; load_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6 held load blocks counting", count, 16'hA5C3);
        end
        rst = 1'b1;
        tick();
        check("R6 held load beats reset", count, 16'hA5C3);
        rst = 1'b0;
        load_n = 1'b1;
        tick();
        check("R6 counting resumes after release", count, 16'hA5C4);
    endtask

    task automatic t_full_cycle();
        cnt_en_n = 1'b1; dir_down = 1'b0;
        do_load(16'h0000);
        cnt_en_n = 1'b0;
        for (int i = 0; i < 65536; i++) begin
            tick();
            check("R2/R5 full up cycle", count, ref_q);
            check_tc("R7 full up cycle");
        end
        check("R8 full cycle returns to start", count, 16'h0000);
    endtask

    task automatic t_mixed();
        do_load(16'h0003);
        for (int i = 0; i < 300; i++) begin
            cnt_en_n = (i % 7 == 3);
            dir_down = ((i / 11) % 2 == 0);
            tick();
            check("R2/R3/R4 mixed sequence", count, ref_q);
            check_tc("R7 mixed sequence");
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_up();
        t_down();
        t_hold();
        t_carry();
        t_wrap();
        t_tc();
        t_load_held();
        t_full_cycle();
        t_mixed();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule